// File: doc/BRIEF.md
# UART Receive Character Queue

This block buffers received characters on the receive side of a UART. An upstream bit sampler asserts a one-cycle strobe when it has seen the stop bit of a character, together with the character's data word and its parity and framing error bits. The character is first captured in a single holding stage that stands in for the receive shift register. From there it moves into a four-entry first-in first-out store. Each stored entry keeps its own error bits, so the flags presented with the head word always belong to that word.

The consumer sees a data-available flag and the head entry, and it pops the head with a read strobe. A one-cycle receive interrupt is raised when a character moves from the holding stage into the store, subject to a two-bit fill-level select. If the store is full and the holding stage has a completed character it cannot pass on, an overrun flag is set. The flag holds until an explicit clear strobe or a reset. While it is set, new characters are refused, and everything already held stays readable.

Top module: `uart_rx_queue`

## Requirements
- R1: With no reads, five completed characters are all retained (four in the store, one in the holding stage) and come out later in arrival order.
- R2: `data_avail` is 1 exactly when the store holds at least one entry and 0 when it is empty.
- R3: A read strobe while data is available removes the head. From the next cycle `rd_data`, `rd_perr` and `rd_ferr` show the following entry, with the error bits that arrived with that character.
- R4: A read strobe while the store is empty changes nothing: the head outputs keep their values and the fill level does not move.
- R5: With `irq_sel` = 2'b00 or 2'b01, `rx_irq` is high for one cycle, one cycle after every transfer from the holding stage into the store.
- R6: With `irq_sel` = 2'b10, `rx_irq` pulses only for a transfer that leaves exactly 3 entries in the store.
- R7: With `irq_sel` = 2'b11, `rx_irq` pulses only for a transfer that leaves the store full (4 entries).
- R8: `ovr_err` rises one cycle after a cycle in which the store is full, the holding stage holds a completed character, and no read occurs. It stays 0 while the store has room.
- R9: While `ovr_err` is 1, arriving characters are discarded. The held and stored characters stay intact and drain normally. Reception resumes after the flag is cleared.
- R10: `ovr_err` stays set until `ovr_clr` is pulsed (0 in the next cycle) or reset is applied. Reset also empties the store.
- R11: A read and a transfer in the same cycle leave the fill level unchanged and keep arrival order. A character in the holding stage moves into the store in the cycle after a read frees a place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| char_stb | input | 1 | Stop bit seen: character complete, one-cycle strobe |
| char_data | input | DATA_W | Completed character data |
| char_perr | input | 1 | Parity error of the completed character |
| char_ferr | input | 1 | Framing error of the completed character |
| rd_pop | input | 1 | Read strobe, pops the head entry |
| irq_sel | input | 2 | Interrupt fill-level select (00/01 every, 10 three, 11 full) |
| ovr_clr | input | 1 | Clears the overrun flag |
| data_avail | output | 1 | Store holds at least one entry |
| rd_data | output | DATA_W | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
A wrong fill count shows up at the ports within a few reads. Either `data_avail` stays high past the last real character or drops early, or the interrupt pulse lands on the wrong transfer under the 10 and 11 selects. Pointer or slot corruption appears as soon as the affected entry reaches the head, as wrong data or as error bits that belong to a neighbouring character. A faulty holding-stage or overrun path becomes visible only when the queue is driven to five characters. There the fifth character goes missing, or a sixth one appears, at the end of the drain, and `ovr_err` is wrong one cycle after the full condition.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  // Fill-level select for the receive interrupt
  typedef enum logic [1:0] {
    LVL_EACH_A = 2'b00,
    LVL_EACH_B = 2'b01,
    LVL_THREE  = 2'b10,
    LVL_FULL   = 2'b11
  } rxq_lvl_e;

  // True when a transfer that leaves 'fill' entries should raise the interrupt
  function automatic logic rxq_lvl_hit(input rxq_lvl_e sel,
                                       input int unsigned fill,
                                       input int unsigned depth);
    logic hit;
    case (sel)
      LVL_THREE: hit = (fill == depth - 1);
      LVL_FULL:  hit = (fill == depth);
      default:   hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/uart_rxq_hold.sv
// Single-character holding stage between the bit sampler and the store.
module uart_rxq_hold #(
  parameter int ENT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arrive,
  input  logic [ENT_W-1:0] arrive_ent,
  input  logic             frozen,
  input  logic             room,
  output logic             held,
  output logic [ENT_W-1:0] held_ent,
  output logic             push
);

  logic load;
  logic held_en;
  logic held_d;

  always_comb begin
    push    = held & room;
    load    = arrive & ~frozen & (~held | push);
    held_en = load | push;
    held_d  = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= 1'b0;
    else if (held_en) held <= held_d;
  end

  always_ff @(posedge clk) begin
    if (load) held_ent <= arrive_ent;
  end

endmodule

// File: rtl/uart_rxq_store.sv
// Circular store of DEPTH entries with fill count.
module uart_rxq_store #(
  parameter int ENT_W = 11,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic             pop_req,
  output logic [ENT_W-1:0] head,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] fill_next,
  output logic             pop
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr, rd_ptr_d;
  logic [ENT_W-1:0] slot_q [DEPTH];

  always_comb begin
    pop       = pop_req & (fill != '0);
    fill_next = fill + CNT_W'(push) - CNT_W'(pop);
    wr_ptr_d  = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    rd_ptr_d  = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    head      = slot_q[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push)        wr_ptr <= wr_ptr_d;
      if (pop)         rd_ptr <= rd_ptr_d;
      if (push ^ pop)  fill   <= fill_next;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ENT_W-1:0] q;
    logic             we;
    assign we = push & (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (we) q <= wr_ent;
    end
    assign slot_q[g] = q;
  end

endmodule

// File: rtl/uart_rxq_irq.sv
// Registered one-cycle interrupt on fill-level match at transfer time.
module uart_rxq_irq #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [CNT_W-1:0]       fill_next,
  input  uart_rxq_pkg::rxq_lvl_e sel,
  output logic                   irq
);

  logic hit;
  logic irq_d;

  always_comb begin
    hit   = uart_rxq_pkg::rxq_lvl_hit(sel, int'(fill_next), DEPTH);
    irq_d = push & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

endmodule

// File: rtl/uart_rx_queue.sv
// UART receive queue: holding stage, DEPTH-entry store, threshold interrupt, overrun.
module uart_rx_queue #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_stb,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              rd_pop,
  input  logic [1:0]        irq_sel,
  input  logic              ovr_clr,
  output logic              data_avail,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rx_irq,
  output logic              ovr_err
);

  localparam int ENT_W = DATA_W + 2;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [ENT_W-1:0] in_ent;
  logic [ENT_W-1:0] hold_ent;
  logic [ENT_W-1:0] head_ent;
  logic             held;
  logic             push;
  logic             pop;
  logic             room;
  logic             full;
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] fill_next;
  logic             ovr_set;
  logic             ovr_d;

  assign in_ent = {char_perr, char_ferr, char_data};

  uart_rxq_hold #(.ENT_W(ENT_W)) i_hold (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .arrive     (char_stb),
    .arrive_ent (in_ent),
    .frozen     (ovr_err),
    .room       (room),
    .held       (held),
    .held_ent   (hold_ent),
    .push       (push)
  );

  uart_rxq_store #(
    .ENT_W (ENT_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .PTR_W (PTR_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .push      (push),
    .wr_ent    (hold_ent),
    .pop_req   (rd_pop),
    .head      (head_ent),
    .fill      (fill),
    .fill_next (fill_next),
    .pop       (pop)
  );

  uart_rxq_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_irq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .push      (push),
    .fill_next (fill_next),
    .sel       (uart_rxq_pkg::rxq_lvl_e'(irq_sel)),
    .irq       (rx_irq)
  );

  always_comb begin
    full       = (fill == FULL_LVL);
    room       = ~full;
    data_avail = (fill != '0);
    ovr_set    = held & full & ~pop;
    ovr_d      = ~ovr_clr & (ovr_err | ovr_set);
    rd_data    = head_ent[DATA_W-1:0];
    rd_ferr    = head_ent[DATA_W];
    rd_perr    = head_ent[DATA_W+1];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) ovr_err <= 1'b0;
    else          ovr_err <= ovr_d;
  end

endmodule

// File: rtl/uart_rx_queue_chk.sv
// Property checker bound to the receive queue.
module uart_rx_queue_chk #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3,
  parameter int ENT_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_pop,
  input logic              ovr_clr,
  input logic              data_avail,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_irq,
  input logic              ovr_err,
  input logic              push,
  input logic [ENT_W-1:0]  hold_ent,
  input logic [CNT_W-1:0]  fill
);

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  assert_avail_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_avail) |-> $past(push));

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_avail && rd_pop && !push) |=> $stable(rd_data));

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(push));

  assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(fill) == CNT_W'(DEPTH));

  assert_ovr_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |=> $stable(hold_ent));

  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !ovr_clr) |=> ovr_err);

  assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr |=> !ovr_err);

endmodule

bind uart_rx_queue uart_rx_queue_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W),
  .ENT_W  (ENT_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_pop     (rd_pop),
  .ovr_clr    (ovr_clr),
  .data_avail (data_avail),
  .rd_data    (rd_data),
  .rx_irq     (rx_irq),
  .ovr_err    (ovr_err),
  .push       (push),
  .hold_ent   (hold_ent),
  .fill       (fill)
);

// File: tb/test_uart_rx_queue.sv
module test_uart_rx_queue;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       char_stb;
  logic [8:0] char_data;
  logic       char_perr;
  logic       char_ferr;
  logic       rd_pop;
  logic [1:0] irq_sel;
  logic       ovr_clr;
  logic       data_avail;
  logic [8:0] rd_data;
  logic       rd_perr;
  logic       rd_ferr;
  logic       rx_irq;
  logic       ovr_err;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  uart_rx_queue #(.DATA_W(9), .DEPTH(4)) i_uart_rx_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_stb   (char_stb),
    .char_data  (char_data),
    .char_perr  (char_perr),
    .char_ferr  (char_ferr),
    .rd_pop     (rd_pop),
    .irq_sel    (irq_sel),
    .ovr_clr    (ovr_clr),
    .data_avail (data_avail),
    .rd_data    (rd_data),
    .rd_perr    (rd_perr),
    .rd_ferr    (rd_ferr),
    .rx_irq     (rx_irq),
    .ovr_err    (ovr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int d, input bit p, input bit f);
    @(negedge clk);
    char_stb  = 1'b1;
    char_data = d[8:0];
    char_perr = p;
    char_ferr = f;
    @(negedge clk);
    char_stb  = 1'b0;
  endtask

  task automatic pop_check(input string req, input int d, input bit p, input bit f);
    chk(req, int'(data_avail), 1);
    chk(req, int'(rd_data), d);
    chk(req, int'(rd_perr), int'(p));
    chk(req, int'(rd_ferr), int'(f));
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset avail", int'(data_avail), 0);
    chk("R10 reset irq", int'(rx_irq), 0);
    chk("R10 reset ovr", int'(ovr_err), 0);
  endtask

  task automatic t_order;
    irq_sel = 2'b00;
    send(9'h1A5, 1'b0, 1'b0);
    send(9'h05A, 1'b1, 1'b0);
    send(9'h0FF, 1'b0, 1'b1);
    idle(2);
    chk("R2 avail with data", int'(data_avail), 1);
    pop_check("R3 head 1", 9'h1A5, 1'b0, 1'b0);
    pop_check("R3 head 2", 9'h05A, 1'b1, 1'b0);
    pop_check("R3 head 3", 9'h0FF, 1'b0, 1'b1);
    chk("R2 avail empty", int'(data_avail), 0);
  endtask

  task automatic t_empty_read;
    int hd;
    bit hp;
    bit hf;
    send(9'h033, 1'b1, 1'b1);
    idle(2);
    pop_check("R3 single", 9'h033, 1'b1, 1'b1);
    hd = int'(rd_data);
    hp = rd_perr;
    hf = rd_ferr;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
    chk("R4 empty read data", int'(rd_data), hd);
    chk("R4 empty read perr", int'(rd_perr), int'(hp));
    chk("R4 empty read ferr", int'(rd_ferr), int'(hf));
    chk("R4 empty read avail", int'(data_avail), 0);
    send(9'h0C3, 1'b0, 1'b0);
    idle(2);
    pop_check("R4 level unchanged", 9'h0C3, 1'b0, 1'b0);
    chk("R4 empty after one", int'(data_avail), 0);
  endtask

  task automatic t_irq(input string req, input logic [1:0] sel, input logic [3:0] exp);
    irq_sel = sel;
    for (int i = 0; i < 4; i++) begin
      send(9'h100 + int'(sel) * 16 + i, 1'b0, 1'b0);
      @(negedge clk);
      chk(req, int'(rx_irq), int'(exp[i]));
      @(negedge clk);
      chk(req, int'(rx_irq), 0);
    end
    for (int i = 0; i < 4; i++) begin
      pop_check(req, 9'h100 + int'(sel) * 16 + i, 1'b0, 1'b0);
    end
    chk(req, int'(data_avail), 0);
  endtask

  task automatic t_overrun;
    irq_sel = 2'b00;
    for (int i = 0; i < 4; i++) send(9'h080 + i, i[0], i[1]);
    idle(2);
    chk("R8 no overrun at four", int'(ovr_err), 0);
    send(9'h084, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8 overrun on fifth", int'(ovr_err), 1);
    send(9'h111, 1'b0, 1'b0);
    idle(2);
    chk("R10 overrun held", int'(ovr_err), 1);
    for (int i = 0; i < 4; i++) pop_check("R1 drain", 9'h080 + i, i[0], i[1]);
    pop_check("R11 fifth after pop", 9'h084, 1'b1, 1'b1);
    chk("R9 arrival discarded", int'(data_avail), 0);
    chk("R10 sticky after drain", int'(ovr_err), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk("R10 cleared", int'(ovr_err), 0);
    send(9'h0AA, 1'b0, 1'b1);
    idle(2);
    pop_check("R9 resumes", 9'h0AA, 1'b0, 1'b1);
  endtask

  task automatic t_simul;
    irq_sel = 2'b00;
    send(9'h011, 1'b0, 1'b0);
    send(9'h022, 1'b1, 1'b0);
    idle(2);
    chk("R11 head before", int'(rd_data), 9'h011);
    char_stb  = 1'b1;
    char_data = 9'h044;
    char_perr = 1'b0;
    char_ferr = 1'b1;
    @(negedge clk);
    char_stb = 1'b0;
    rd_pop   = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    idle(1);
    pop_check("R11 order 1", 9'h022, 1'b1, 1'b0);
    pop_check("R11 order 2", 9'h044, 1'b0, 1'b1);
    chk("R11 level", int'(data_avail), 0);
  endtask

  task automatic t_reset_mid;
    send(9'h001, 1'b0, 1'b0);
    send(9'h002, 1'b0, 1'b0);
    send(9'h003, 1'b0, 1'b0);
    idle(2);
    rst_n = 1'b0;
    #1;
    chk("R10 mid reset avail", int'(data_avail), 0);
    chk("R10 mid reset irq", int'(rx_irq), 0);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    chk("R10 empty after reset", int'(data_avail), 0);
    send(9'h1EE, 1'b1, 1'b0);
    idle(2);
    pop_check("R10 fresh head", 9'h1EE, 1'b1, 1'b0);
    chk("R10 one entry", int'(data_avail), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    char_stb  = 1'b0;
    char_data = '0;
    char_perr = 1'b0;
    char_ferr = 1'b0;
    rd_pop    = 1'b0;
    irq_sel   = 2'b00;
    ovr_clr   = 1'b0;
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_order;
    t_empty_read;
    t_irq("R5 sel00", 2'b00, 4'b1111);
    t_irq("R5 sel01", 2'b01, 4'b1111);
    t_irq("R6 sel10", 2'b10, 4'b0100);
    t_irq("R7 sel11", 2'b11, 4'b1000);
    t_overrun;
    t_simul;
    t_reset_mid;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule